// File: doc/BRIEF.md
# Condition flag compare unit

This block decides a single true/false condition bit for a processor datapath and keeps it, together with two sign bits used to set up a later step-wise division. Every issued operation presents two 32-bit register operands, an 8-bit immediate and a 4-bit operation code. Comparisons, bit tests and string matches reduce the operands to one bit that is written into the condition flag. Two setup operations prepare the division sign bits. Two further operations force the condition flag to a fixed value.

The flags are registered. An operation is taken on a rising clock edge where the valid strobe is high, and its result is visible on the flag outputs right after that edge. Operand A stands for the destination-side register (Rn, also the dividend) and operand B for the source-side register (Rm, also the divisor).

Top module: `cflag_unit`

## Requirements
- R1: While rst_n is low, flag_t, flag_m and flag_q are all 0, and they stay 0 until the first valid operation.
- R2: On an edge where op_valid is low, all three flags keep their values whatever the other inputs are.
- R3: Code 0 (equal) sets flag_t to 1 when op_a equals op_b in all 32 bits, else to 0.
- R4: Code 1 sets flag_t when op_a >= op_b and code 2 sets it when op_a > op_b, both taken as unsigned numbers.
- R5: Code 3 sets flag_t when op_a >= op_b and code 4 sets it when op_a > op_b, both taken as signed two's-complement numbers.
- R6: Code 5 sets flag_t when at least one of the four byte lanes (bits 7:0, 15:8, 23:16, 31:24) holds the same value in op_a and op_b.
- R7: Code 6 sets flag_t when op_a AND op_b is zero; code 7 sets it when op_a AND the zero-extended op_imm is zero.
- R8: Code 8 sets flag_t when op_a, signed, is >= 0; code 9 sets it when op_a, signed, is > 0.
- R9: Code 10 (signed divide setup) loads flag_q with op_a[31], flag_m with op_b[31] and flag_t with their XOR, all on the same edge.
- R10: Code 11 (unsigned divide setup) clears flag_t, flag_m and flag_q together.
- R11: Code 12 forces flag_t to 1 and code 13 forces it to 0, regardless of op_a, op_b and op_imm.
- R12: Codes 0 to 9, 12 and 13 leave flag_m and flag_q unchanged.
- R13: Codes 14 and 15 change none of the three flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation issue strobe |
| op_code | input | 4 | Operation select (codes listed in the requirements) |
| op_a | input | 32 | First operand (Rn, dividend) |
| op_b | input | 32 | Second operand (Rm, divisor) |
| op_imm | input | 8 | Immediate test mask, zero-extended |
| flag_t | output | 1 | Condition flag |
| flag_m | output | 1 | Divisor sign bit |
| flag_q | output | 1 | Dividend sign / quotient bit |

## Verification
The assertions assume that op_code, op_a and op_b are known, stable values at every rising edge after reset, since several properties compare a flag with the past value of an operand. The stimulus changes inputs only on falling edges and holds them for a full cycle. It drives defined zeros from time zero, so no sampled value is unknown. Idle cycles still carry random codes and operands, which exercises the hold rule while the inputs are moving.

// File: rtl/cflag_pkg.sv
package cflag_pkg;

  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_EQ   = 4'd0,
    OP_UGE  = 4'd1,
    OP_UGT  = 4'd2,
    OP_SGE  = 4'd3,
    OP_SGT  = 4'd4,
    OP_LANE = 4'd5,
    OP_TST  = 4'd6,
    OP_TSTI = 4'd7,
    OP_NNEG = 4'd8,
    OP_POS  = 4'd9,
    OP_DVS  = 4'd10,
    OP_DVU  = 4'd11,
    OP_SETT = 4'd12,
    OP_CLRT = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } cflag_op_e;

  typedef struct packed {
    logic t;
    logic m;
    logic q;
  } cflag_bits_t;

endpackage

// File: rtl/cflag_cond.sv
module cflag_cond
  import cflag_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 8,
  parameter int unsigned LANE_W = 8
) (
  input  cflag_op_e         op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [IMM_W-1:0]  imm,
  output logic              cond
);

  localparam int unsigned LANES = DATA_W / LANE_W;
  localparam int unsigned MSB   = DATA_W - 1;

  // signed less-than built from sign bits and an unsigned compare
  function automatic logic f_slt(input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y);
    if (x[MSB] != y[MSB]) return x[MSB];
    return x < y;
  endfunction

  function automatic logic f_ult(input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y);
    return x < y;
  endfunction

  logic [LANES-1:0]  lane_eq;
  logic              any_lane;
  logic [DATA_W-1:0] imm_ext;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_eq[g] = (a[g*LANE_W +: LANE_W] == b[g*LANE_W +: LANE_W]);
  end

  assign any_lane = |lane_eq;
  assign imm_ext  = {{(DATA_W-IMM_W){1'b0}}, imm};

  always_comb begin
    unique case (op)
      OP_EQ:   cond = (a == b);
      OP_UGE:  cond = !f_ult(a, b);
      OP_UGT:  cond = f_ult(b, a);
      OP_SGE:  cond = !f_slt(a, b);
      OP_SGT:  cond = f_slt(b, a);
      OP_LANE: cond = any_lane;
      OP_TST:  cond = ((a & b) == '0);
      OP_TSTI: cond = ((a & imm_ext) == '0);
      OP_NNEG: cond = !a[MSB];
      OP_POS:  cond = !a[MSB] && (a != '0);
      default: cond = 1'b0;
    endcase
  end

endmodule

// File: rtl/cflag_next.sv
module cflag_next
  import cflag_pkg::*;
(
  input  logic        valid,
  input  cflag_op_e   op,
  input  logic        cond,
  input  logic        a_msb,
  input  logic        b_msb,
  output logic        wr_t,
  output logic        wr_mq,
  output cflag_bits_t nxt
);

  logic is_cond;
  logic is_div;

  assign is_cond = (op <= OP_POS);
  assign is_div  = (op == OP_DVS) || (op == OP_DVU);

  assign wr_t  = valid && (is_cond || is_div || op == OP_SETT || op == OP_CLRT);
  assign wr_mq = valid && is_div;

  always_comb begin
    nxt = '0;
    if (is_cond) begin
      nxt.t = cond;
    end else if (op == OP_DVS) begin
      nxt.q = a_msb;
      nxt.m = b_msb;
      nxt.t = a_msb ^ b_msb;
    end else if (op == OP_SETT) begin
      nxt.t = 1'b1;
    end
  end

endmodule

// File: rtl/cflag_state.sv
module cflag_state
  import cflag_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_t,
  input  logic        wr_mq,
  input  cflag_bits_t nxt,
  output cflag_bits_t cur
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur <= '0;
    end else begin
      if (wr_t) cur.t <= nxt.t;
      if (wr_mq) begin
        cur.m <= nxt.m;
        cur.q <= nxt.q;
      end
    end
  end

endmodule

// File: rtl/cflag_unit.sv
module cflag_unit
  import cflag_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 8,
  parameter int unsigned LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [OP_W-1:0]   op_code,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [IMM_W-1:0]  op_imm,
  output logic              flag_t,
  output logic              flag_m,
  output logic              flag_q
);

  cflag_op_e   op;
  logic        cond_t;
  logic        wr_t;
  logic        wr_mq;
  cflag_bits_t nxt;
  cflag_bits_t cur;

  assign op = cflag_op_e'(op_code);

  cflag_cond #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W),
    .LANE_W (LANE_W)
  ) u_cond (
    .op   (op),
    .a    (op_a),
    .b    (op_b),
    .imm  (op_imm),
    .cond (cond_t)
  );

  cflag_next u_next (
    .valid (op_valid),
    .op    (op),
    .cond  (cond_t),
    .a_msb (op_a[DATA_W-1]),
    .b_msb (op_b[DATA_W-1]),
    .wr_t  (wr_t),
    .wr_mq (wr_mq),
    .nxt   (nxt)
  );

  cflag_state u_state (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_t  (wr_t),
    .wr_mq (wr_mq),
    .nxt   (nxt),
    .cur   (cur)
  );

  assign flag_t = cur.t;
  assign flag_m = cur.m;
  assign flag_q = cur.q;

endmodule

// File: rtl/cflag_unit_chk.sv
module cflag_unit_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic [3:0]        op_code,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic              wr_mq,
  input logic              flag_t,
  input logic              flag_m,
  input logic              flag_q
);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable({flag_t, flag_m, flag_q}));

  // R3
  eq_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd0) |=> (flag_t == ($past(op_a) == $past(op_b))));

  // R9
  div_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd10) |=>
      (flag_q == $past(op_a[DATA_W-1]) && flag_m == $past(op_b[DATA_W-1])
       && flag_t == (flag_q ^ flag_m)));

  // R10
  div_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd11) |=> (!flag_t && !flag_m && !flag_q));

  // R11
  force_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd12) |=> flag_t);

  // R11
  force_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd13) |=> !flag_t);

  // R12
  mq_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mq |=> $stable({flag_m, flag_q}));

  // R13
  reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code >= 4'd14) |=> $stable({flag_t, flag_m, flag_q}));

endmodule

bind cflag_unit cflag_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .op_code  (op_code),
  .op_a     (op_a),
  .op_b     (op_b),
  .wr_mq    (wr_mq),
  .flag_t   (flag_t),
  .flag_m   (flag_m),
  .flag_q   (flag_q)
);

// File: tb/cflag_unit_test.sv
module cflag_unit_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [7:0]  op_imm = '0;
  logic        flag_t, flag_m, flag_q;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    logic  t;
    logic  m;
    logic  q;
    string req;
  } exp_item_t;

  exp_item_t sb[$];
  logic mt = 1'b0, mm = 1'b0, mq = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cflag_unit uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .op_a     (op_a),
    .op_b     (op_b),
    .op_imm   (op_imm),
    .flag_t   (flag_t),
    .flag_m   (flag_m),
    .flag_q   (flag_q)
  );

  function automatic string req_of(input logic v, input logic [3:0] c);
    if (!v) return "R2";
    case (c)
      4'd0: return "R3";
      4'd1, 4'd2: return "R4";
      4'd3, 4'd4: return "R5";
      4'd5: return "R6";
      4'd6, 4'd7: return "R7";
      4'd8, 4'd9: return "R8";
      4'd10: return "R9";
      4'd11: return "R10";
      4'd12, 4'd13: return "R11";
      default: return "R13";
    endcase
  endfunction

  // reference: signed order via sign-bit flip, lanes via a loop
  function automatic logic ref_cond(input logic [3:0] c, input logic [31:0] a,
                                    input logic [31:0] b, input logic [7:0] im);
    logic [31:0] fa, fb;
    logic hit;
    fa = a ^ 32'h8000_0000;
    fb = b ^ 32'h8000_0000;
    hit = 1'b0;
    case (c)
      4'd0: return a == b;
      4'd1: return a >= b;
      4'd2: return a > b;
      4'd3: return fa >= fb;
      4'd4: return fa > fb;
      4'd5: begin
        for (int k = 0; k < 4; k++) if (a[8*k +: 8] == b[8*k +: 8]) hit = 1'b1;
        return hit;
      end
      4'd6: return (a & b) == 32'd0;
      4'd7: return (a[7:0] & im) == 8'd0;
      4'd8: return fa >= 32'h8000_0000;
      4'd9: return fa > 32'h8000_0000;
      default: return 1'b0;
    endcase
  endfunction

  task automatic issue(input logic v, input logic [3:0] c, input logic [31:0] a,
                       input logic [31:0] b, input logic [7:0] im);
    exp_item_t it;
    @(negedge clk);
    op_valid = v;
    op_code  = c;
    op_a     = a;
    op_b     = b;
    op_imm   = im;
    if (v) begin
      if (c <= 4'd9) mt = ref_cond(c, a, b, im);
      else if (c == 4'd10) begin mq = a[31]; mm = b[31]; mt = a[31] ^ b[31]; end
      else if (c == 4'd11) begin mt = 1'b0; mm = 1'b0; mq = 1'b0; end
      else if (c == 4'd12) mt = 1'b1;
      else if (c == 4'd13) mt = 1'b0;
    end
    it.t = mt; it.m = mm; it.q = mq; it.req = req_of(v, c);
    sb.push_back(it);
  endtask

  // monitor: one item per issued cycle, compared just after the update edge
  always @(posedge clk) begin
    exp_item_t it;
    #1;
    if (sb.size() > 0) begin
      it = sb.pop_front();
      checks++;
      if ({flag_t, flag_m, flag_q} !== {it.t, it.m, it.q}) begin
        bad++;
        $display("FAIL %s: tmq actual=%b%b%b expected=%b%b%b (code %0d a=%h b=%h)",
                 it.req, flag_t, flag_m, flag_q, it.t, it.m, it.q,
                 op_code, op_a, op_b);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] ra, rb;
    repeat (3) @(posedge clk);
    #2;
    checks++;
    if ({flag_t, flag_m, flag_q} !== 3'b000) begin
      bad++;
      $display("FAIL R1: tmq actual=%b%b%b expected=000", flag_t, flag_m, flag_q);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R1: flags stay clear across idle cycles after reset
    issue(1'b0, 4'd12, 32'hFFFF_FFFF, 32'h0, 8'hFF);

    // R9 with both signs, then R12 keeps m/q through compares
    issue(1'b1, 4'd10, 32'h8000_0000, 32'h0000_0001, 8'h00);
    issue(1'b1, 4'd0, 32'h1234_5678, 32'h1234_5678, 8'h00);
    issue(1'b1, 4'd12, 32'h0, 32'h0, 8'h00);
    issue(1'b1, 4'd13, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'hFF);
    issue(1'b1, 4'd10, 32'h8000_0000, 32'hF000_0000, 8'h00);
    issue(1'b1, 4'd14, 32'h0, 32'h0, 8'h00);
    issue(1'b1, 4'd15, 32'h1, 32'h2, 8'h00);
    issue(1'b1, 4'd11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 8'h00);

    // R4 R5 corners: most negative against most positive
    for (int c = 1; c <= 4; c++) begin
      issue(1'b1, 4'(c), 32'h8000_0000, 32'h7FFF_FFFF, 8'h00);
      issue(1'b1, 4'(c), 32'h7FFF_FFFF, 32'h8000_0000, 8'h00);
      issue(1'b1, 4'(c), 32'h7FFF_FFFF, 32'h7FFF_FFFF, 8'h00);
    end

    // R6: exactly one lane equal, then no lane equal
    issue(1'b1, 4'd5, 32'h1122_3344, 32'h5566_7744, 8'h00);
    issue(1'b1, 4'd5, 32'h1122_3344, 32'h5566_3388, 8'h00);
    issue(1'b1, 4'd5, 32'h1122_3344, 32'h5522_7788, 8'h00);
    issue(1'b1, 4'd5, 32'h1122_3344, 32'h1166_7788, 8'h00);
    issue(1'b1, 4'd5, 32'h1122_3344, 32'h2233_4455, 8'h00);

    // R7 and R8 boundaries
    issue(1'b1, 4'd7, 32'hFFFF_FF0F, 32'h0, 8'hF0);
    issue(1'b1, 4'd7, 32'h0000_0100, 32'h0, 8'hFF);
    issue(1'b1, 4'd7, 32'h0000_0001, 32'h0, 8'h01);
    issue(1'b1, 4'd6, 32'hAAAA_AAAA, 32'h5555_5555, 8'h00);
    issue(1'b1, 4'd8, 32'h0, 32'h0, 8'h00);
    issue(1'b1, 4'd9, 32'h0, 32'h0, 8'h00);
    issue(1'b1, 4'd9, 32'h0000_0001, 32'h0, 8'h00);
    issue(1'b1, 4'd8, 32'hFFFF_FFFF, 32'h0, 8'h00);

    // random mix, all codes, with idle cycles (R2) and forced equal operands
    for (int n = 0; n < 3000; n++) begin
      ra = $urandom;
      rb = ($urandom_range(0, 3) == 0) ? ra : $urandom;
      if ($urandom_range(0, 3) == 0) rb[15:8] = ra[15:8];
      issue(($urandom_range(0, 4) != 0), 4'($urandom_range(0, 15)), ra, rb,
            8'($urandom));
    end

    issue(1'b0, 4'd0, 32'h0, 32'h0, 8'h00);
    repeat (3) @(posedge clk);
    #2;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule